// File: doc/BRIEF.md
# ADC Conversion Sequencer with Trigger Selection

This block is the digital controller that sits around a 10-bit successive-approximation converter, its input multiplexer and an optional gain stage. Software sets up a conversion through a two-word register port. The setup names the channel, the gain, the trigger source and the active edge of the external trigger. The block decodes the 4-bit channel code into positive and negative multiplexer selects, a differential flag and an offset-trim flag. It then waits for the chosen trigger and runs the front-end phases and the binary search. The 10-bit result is latched and a ready flag is raised.

Time inside a conversion is counted in half periods of the SAR clock. One half period lasts `HALF_DIV` system clocks. This keeps the gain-16 sequence of 26.5 SAR clocks exact. The comparator is outside the block: the block drives a trial code on `dac_code`, and `cmp_in` answers whether the sampled input is at or above it.

Top module: `adc_seq`

## Requirements
- R1: Channel codes 0000 to 0111 set `mux_pos` to the code value, with `mux_diff` = 0 (reference is ground) and `trim_en` = 0.
- R2: Codes 1010, 1011, 1100 and 1101 select the pairs 0/1, 2/3, 4/5 and 6/7. `mux_pos` is the even input, `mux_neg` is the odd input and `mux_diff` = 1.
- R3: Code 1111 sets `trim_en` = 1 and `mux_diff` = 1, with both selects at 0.
- R4: A trigger with code 1000, 1001 or 1110 starts no conversion and sets the error flag (status bit 14). The next accepted conversion clears the flag.
- R5: At gain 1 (control bit 4 = 0), a conversion runs a track phase of `TRACK_HALF` half periods and then a convert phase of 2·NBITS half periods. `busy` is high for 32·HALF_DIV clocks.
- R6: At gain 16 (control bit 4 = 1), a conversion runs an amplify phase of `AMP_HALF` half periods, then track, then convert. `busy` is high for 53·HALF_DIV clocks, and `gain_on` is high.
- R7: The result is the binary-search outcome from `cmp_in`, MSB first. It is readable in status bits 9:0. `ready` (status bit 12) rises when the result is latched and clears when the next conversion starts. `ready` and `busy` are never high together.
- R8: Control bits 6:5 select the trigger: 0 = software start (write control word with bit 8 set), 1 = continuous back-to-back, 2 = `timer_evt` pulse, 3 = external pin edge. Sources that are not selected have no effect.
- R9: Control bit 7 selects the active edge of `ext_trig` (0 = rising, 1 = falling). The opposite edge starts nothing.
- R10: A trigger that arrives while `busy` is high is ignored: it neither lengthens the conversion nor queues a new one.
- R11: After reset, `busy`, `ready`, the error flag, the result and `phase` are all zero.
- R12: The multiplexer selects, `trim_en`, `mux_diff` and `gain_on` stay constant throughout a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status/result word |
| reg_wdata | input | 9 | Control write data: [3:0] channel, [4] gain16, [6:5] source, [7] falling edge, [8] start |
| reg_rdata | output | 16 | Read data for the word at `reg_addr` |
| timer_evt | input | 1 | Internal timer event pulse |
| ext_trig | input | 1 | External trigger pin (asynchronous) |
| cmp_in | input | 1 | Comparator: input at or above `dac_code` |
| dac_code | output | NBITS | Trial code during the convert phase |
| phase | output | 2 | 0 idle, 1 amplify, 2 track, 3 convert |
| gain_on | output | 1 | Gain stage used by the current/last conversion |
| mux_pos | output | 3 | Positive-side input select |
| mux_neg | output | 3 | Negative-side input select (used when differential) |
| mux_diff | output | 1 | Differential measurement |
| trim_en | output | 1 | Zero-offset trim measurement |
| busy | output | 1 | Conversion in progress |
| ready | output | 1 | Result available |

## Verification
The hardest state to reach is a second trigger landing inside a running conversion. The stimulus must hit this window at a precise cycle and then prove that the trigger left no trace. The bench counts `busy` cycles. Twenty cycles into a conversion, it fires a software start and a timer pulse in the same cycle. It then confirms that the conversion length is unchanged and that no conversion follows. The external edge is driven through the synchronizer in both polarities, so the wrong edge is shown to do nothing. Continuous mode is also stopped by a control write made in the middle of a conversion.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int NBITS      = 10,
  parameter int HALF_DIV   = 2,
  parameter int TRACK_HALF = 12,
  parameter int AMP_HALF   = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [8:0]       reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             timer_evt,
  input  logic             ext_trig,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic [1:0]       phase,
  output logic             gain_on,
  output logic [2:0]       mux_pos,
  output logic [2:0]       mux_neg,
  output logic             mux_diff,
  output logic             trim_en,
  output logic             busy,
  output logic             ready
);
  localparam int CONV_HALF = 2 * NBITS;
  localparam int CW = $clog2(AMP_HALF + TRACK_HALF + CONV_HALF + 1);
  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [1:0] P_IDLE = 2'd0, P_AMP = 2'd1, P_TRK = 2'd2, P_CNV = 2'd3;

  logic [7:0]       ctrl_q;
  logic             sw_req, err_q;
  logic [2:0]       pin_s;
  logic [PW-1:0]    pre;
  logic [CW-1:0]    cnt, plen;
  logic [NBITS-1:0] msk, result_q, sar_keep;
  logic [1:0]       pidx;
  logic             d_ok, d_diff, d_trim, trig, fire, half, last, pin_edge;
  logic [2:0]       d_pos, d_neg;

  assign busy     = (phase != P_IDLE);
  assign pidx     = ctrl_q[1:0] - 2'd2;
  assign pin_edge = ctrl_q[7] ? (pin_s[2] & ~pin_s[1]) : (~pin_s[2] & pin_s[1]);
  assign half     = busy && (pre == PW'(HALF_DIV - 1));
  assign plen     = (phase == P_AMP) ? CW'(AMP_HALF) :
                    (phase == P_TRK) ? CW'(TRACK_HALF) : CW'(CONV_HALF);
  assign last     = half && (cnt == plen - 1'b1);
  assign sar_keep = cmp_in ? dac_code : (dac_code & ~msk);
  assign fire     = trig && !busy;
  assign reg_rdata = reg_addr ? {1'b0, err_q, busy, ready, {(12-NBITS){1'b0}}, result_q}
                              : {8'd0, ctrl_q};

  always_comb begin
    case (ctrl_q[6:5])
      2'd0:    trig = sw_req;
      2'd1:    trig = 1'b1;
      2'd2:    trig = timer_evt;
      default: trig = pin_edge;
    endcase
  end

  always_comb begin
    d_ok = 1'b1; d_pos = ctrl_q[2:0]; d_neg = 3'd0; d_diff = 1'b0; d_trim = 1'b0;
    if (ctrl_q[3]) begin
      case (ctrl_q[2:0])
        3'b010, 3'b011, 3'b100, 3'b101: begin
          d_pos = {pidx, 1'b0}; d_neg = {pidx, 1'b1}; d_diff = 1'b1;
        end
        3'b111: begin
          d_pos = 3'd0; d_diff = 1'b1; d_trim = 1'b1;
        end
        default: begin
          d_pos = 3'd0; d_ok = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; sw_req <= 1'b0; err_q <= 1'b0; pin_s <= '0;
      pre <= '0; cnt <= '0; msk <= '0; dac_code <= '0; result_q <= '0;
      phase <= P_IDLE; gain_on <= 1'b0; ready <= 1'b0;
      mux_pos <= '0; mux_neg <= '0; mux_diff <= 1'b0; trim_en <= 1'b0;
    end else begin
      sw_req <= reg_wr && !reg_addr && reg_wdata[8];
      if (reg_wr && !reg_addr) ctrl_q <= reg_wdata[7:0];
      pin_s <= {pin_s[1], pin_s[0], ext_trig};
      if (fire) begin
        if (!d_ok) begin
          err_q <= 1'b1;
        end else begin
          err_q    <= 1'b0;
          ready    <= 1'b0;
          phase    <= ctrl_q[4] ? P_AMP : P_TRK;
          gain_on  <= ctrl_q[4];
          mux_pos  <= d_pos;
          mux_neg  <= d_neg;
          mux_diff <= d_diff;
          trim_en  <= d_trim;
          pre      <= '0;
          cnt      <= '0;
          msk      <= '0;
          dac_code <= '0;
        end
      end else if (busy) begin
        pre <= half ? '0 : pre + 1'b1;
        if (half) begin
          cnt <= last ? '0 : cnt + 1'b1;
          if (phase == P_CNV && cnt[0]) begin
            dac_code <= sar_keep | (msk >> 1);
            msk      <= msk >> 1;
          end
          if (last) begin
            case (phase)
              P_AMP: phase <= P_TRK;
              P_TRK: begin
                phase    <= P_CNV;
                dac_code <= {1'b1, {(NBITS-1){1'b0}}};
                msk      <= {1'b1, {(NBITS-1){1'b0}}};
              end
              default: begin
                phase    <= P_IDLE;
                result_q <= sar_keep;
                ready    <= 1'b1;
                dac_code <= '0;
              end
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NBITS      = 10,
  parameter int HALF_DIV   = 2,
  parameter int TRACK_HALF = 12,
  parameter int AMP_HALF   = 21
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       ready,
  input logic       err,
  input logic [1:0] phase,
  input logic       gain_on,
  input logic [2:0] mux_pos,
  input logic [2:0] mux_neg,
  input logic       mux_diff,
  input logic       trim_en
);
  int cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else if (busy) cyc <= cyc + 1;
    else cyc <= 0;
  end

  // R5
  conv_after_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && $past(phase) != 2'd3) |-> $past(phase) == 2'd2);
  // R5
  gain1_starts_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd2 && $past(phase) == 2'd0) |-> !gain_on);
  // R6
  amp_needs_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> gain_on);
  // R6
  conv_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cyc == (gain_on ? (AMP_HALF + TRACK_HALF + 2*NBITS)
                                    : (TRACK_HALF + 2*NBITS)) * HALF_DIV);
  // R7
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && busy));
  // R7
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ready);
  // R4
  reject_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);
  // R12
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(mux_pos) && $stable(mux_neg) &&
                                $stable(mux_diff) && $stable(trim_en) && $stable(gain_on)));
endmodule

bind adc_seq adc_seq_chk #(.NBITS(NBITS), .HALF_DIV(HALF_DIV),
                           .TRACK_HALF(TRACK_HALF), .AMP_HALF(AMP_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready), .err(err_q),
  .phase(phase), .gain_on(gain_on), .mux_pos(mux_pos), .mux_neg(mux_neg),
  .mux_diff(mux_diff), .trim_en(trim_en));

// File: tb/adc_seq_bench.sv
module adc_seq_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_addr = 1'b0, timer_evt = 1'b0, ext_trig = 1'b0;
  logic [8:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [9:0] vin = '0, dac_code;
  logic [1:0] phase;
  logic [2:0] mux_pos, mux_neg;
  logic gain_on, mux_diff, trim_en, busy, ready, cmp_in;
  int checks = 0, errors = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  adc_seq u_adc_seq (.*);

  // {code, gain, vin, pos, neg, diff, trim, err}
  localparam logic [23:0] VEC [12] = '{
    {4'h0, 1'b0, 10'd0,    3'd0, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'h7, 1'b1, 10'd1023, 3'd7, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'h3, 1'b0, 10'd341,  3'd3, 3'd0, 1'b0, 1'b0, 1'b0},
    {4'hA, 1'b0, 10'd682,  3'd0, 3'd1, 1'b1, 1'b0, 1'b0},
    {4'hB, 1'b1, 10'd512,  3'd2, 3'd3, 1'b1, 1'b0, 1'b0},
    {4'hC, 1'b0, 10'd511,  3'd4, 3'd5, 1'b1, 1'b0, 1'b0},
    {4'hD, 1'b1, 10'd1,    3'd6, 3'd7, 1'b1, 1'b0, 1'b0},
    {4'hF, 1'b0, 10'd300,  3'd0, 3'd0, 1'b1, 1'b1, 1'b0},
    {4'h8, 1'b0, 10'd5,    3'd0, 3'd0, 1'b0, 1'b0, 1'b1},
    {4'h9, 1'b1, 10'd5,    3'd0, 3'd0, 1'b0, 1'b0, 1'b1},
    {4'hE, 1'b0, 10'd5,    3'd0, 3'd0, 1'b0, 1'b0, 1'b1},
    {4'h5, 1'b1, 10'd777,  3'd5, 3'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] d);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic run_conv(output int n);
    int w = 0;
    while (!busy && w < 12) begin @(negedge clk); w++; end
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic idle_for(input int k, output bit saw);
    saw = 0;
    for (int j = 0; j < k; j++) begin @(negedge clk); if (busy) saw = 1; end
  endtask

  function automatic int exp_len(input bit g);
    return g ? 106 : 64;
  endfunction

  initial begin
    int n;
    bit saw;
    reg_addr = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !ready && phase == 2'd0, "R11", {busy, ready, phase}, 0);
    chk(reg_rdata == 16'd0, "R11", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [23:0] v;
      string tg;
      v = VEC[i];
      vin = v[18:9];
      tg = !v[23] ? "R1" : (v[23:20] == 4'hF) ? "R3" : "R2";
      wr({1'b1, 1'b0, 2'd0, v[19], v[23:20]});
      if (v[0]) begin
        idle_for(12, saw);
        chk(!saw, "R4", saw, 0);
        chk(reg_rdata[14] == 1'b1, "R4", reg_rdata[14], 1);
      end else begin
        run_conv(n);
        chk(n == exp_len(v[19]), v[19] ? "R6" : "R5", n, exp_len(v[19]));
        chk(gain_on == v[19], "R6", gain_on, v[19]);
        chk(reg_rdata[9:0] == v[18:9], "R7", reg_rdata[9:0], v[18:9]);
        chk(ready && reg_rdata[12], "R7", ready, 1);
        chk(reg_rdata[14] == 1'b0, "R4", reg_rdata[14], 0);
        chk(mux_pos == v[8:6], tg, mux_pos, v[8:6]);
        chk(!v[2] || mux_neg == v[5:3], tg, mux_neg, v[5:3]);
        chk(mux_diff == v[2], tg, mux_diff, v[2]);
        chk(trim_en == v[1], tg, trim_en, v[1]);
      end
    end

    // R8: timer selected, software start ignored; then timer pulse starts
    vin = 10'd200;
    wr({1'b1, 1'b0, 2'd2, 1'b0, 4'h1});
    idle_for(12, saw);
    chk(!saw, "R8", saw, 0);
    timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0;
    run_conv(n);
    chk(n == 64 && reg_rdata[9:0] == 10'd200, "R8", reg_rdata[9:0], 200);

    // R8: software selected, timer pulse ignored
    wr({1'b0, 1'b0, 2'd0, 1'b0, 4'h1});
    timer_evt = 1'b1; @(negedge clk); timer_evt = 1'b0;
    idle_for(12, saw);
    chk(!saw, "R8", saw, 0);

    // R10: triggers during a conversion are ignored
    vin = 10'd444;
    wr({1'b1, 1'b0, 2'd0, 1'b0, 4'h2});
    while (!busy) @(negedge clk);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 20) begin
        reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = {1'b1, 1'b0, 2'd0, 1'b0, 4'h2};
        timer_evt = 1'b1;
      end else begin
        reg_wr = 1'b0; reg_addr = 1'b1; timer_evt = 1'b0;
      end
      @(negedge clk);
    end
    reg_wr = 1'b0; reg_addr = 1'b1; timer_evt = 1'b0;
    chk(n == 64, "R10", n, 64);
    idle_for(12, saw);
    chk(!saw, "R10", saw, 0);

    // R8 continuous mode
    vin = 10'd100;
    wr({1'b0, 1'b0, 2'd1, 1'b0, 4'h2});
    run_conv(n);
    chk(n == 64 && ready && reg_rdata[9:0] == 10'd100, "R8", reg_rdata[9:0], 100);
    @(negedge clk);
    chk(busy && !ready, "R8", busy, 1);
    wr({1'b0, 1'b0, 2'd0, 1'b0, 4'h2});
    while (busy) @(negedge clk);
    idle_for(12, saw);
    chk(!saw, "R8", saw, 0);

    // R9 rising edge
    vin = 10'd900;
    wr({1'b0, 1'b0, 2'd3, 1'b0, 4'h6});
    ext_trig = 1'b1;
    run_conv(n);
    chk(n == 64 && reg_rdata[9:0] == 10'd900, "R9", reg_rdata[9:0], 900);
    ext_trig = 1'b0;
    idle_for(12, saw);
    chk(!saw, "R9", saw, 0);
    // R9 falling edge
    vin = 10'd33;
    wr({1'b0, 1'b1, 2'd3, 1'b0, 4'h6});
    ext_trig = 1'b1;
    idle_for(12, saw);
    chk(!saw, "R9", saw, 0);
    ext_trig = 1'b0;
    run_conv(n);
    chk(n == 64 && reg_rdata[9:0] == 10'd33, "R9", reg_rdata[9:0], 33);

    // R11 reset during a conversion
    wr({1'b1, 1'b0, 2'd0, 1'b1, 4'h4});
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!busy && !ready && phase == 2'd0 && reg_rdata == 16'd0, "R11", reg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule